// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital core of a 128-step digitally controlled potentiometer. Three slow, asynchronous control pins drive it: an active-low select, an increment strobe and a direction pin. All three are brought into the system clock domain through synchronizers. A 7-bit tap position then moves one step for each qualified falling edge of the strobe. At either end the position stops and does not wrap. The position is shown both as a binary value and as a one-hot tap select for the switch array.

When the select pin is released while the strobe is high, the current position is written into a modelled non-volatile cell. That cell is a retained register with a programmable write time, and a busy flag is raised while the write is in progress. When the select pin is released while the strobe is low, the block only returns to standby.

After every reset (power-up), the block waits a programmable recall delay. It then loads the retained value back into the tap register. All timing limits are given in nanoseconds and are converted to clock cycles inside the block.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: From reset and through the power-up recall window (`T_POWERUP_NS` converted to cycles after reset release), the position reads 0, the tap select has only bit 0 set, store_busy is low, and strobe edges and deselects have no effect.
- R2: While selected (sel_n low) and not busy, each high-to-low transition of inc_strobe with dir_up high raises the position by exactly one. The new value appears within 3 clock cycles of the edge reaching the pin.
- R3: With dir_up low, the same strobe edge lowers the position by one. The direction may change between strobes while the block stays selected, and each strobe follows the direction present at that edge.
- R4: An up step at position 127 leaves 127, and a down step at position 0 leaves 0 (no wrap-around).
- R5: While sel_n is high, strobe edges do not change the position.
- R6: A low-to-high transition of sel_n while inc_strobe is high captures the position and raises store_busy for exactly `T_STORE_NS` converted to cycles. At the end of that time the captured value is written into the retained cell.
- R7: A low-to-high transition of sel_n while inc_strobe is low stores nothing, and store_busy stays low.
- R8: When the recall window ends, the position takes the value last written into the retained cell, and the cell keeps that value across resets.
- R9: tap_sel always has exactly one bit set, the bit whose index equals wiper_pos.
- R10: While store_busy is high, strobe edges do not move the position, and a further qualified deselect does not start a second store.
- R11: A falling strobe edge counts only if the synchronized strobe was high for at least `T_STROBE_HI_NS` converted to cycles just before it; shorter high pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up), released synchronously |
| sel_n | input | 1 | Active-low select pin, asynchronous |
| inc_strobe | input | 1 | Increment strobe pin; falling edge steps the wiper, asynchronous |
| dir_up | input | 1 | Direction pin: 1 steps toward 127, 0 toward 0, asynchronous |
| wiper_pos | output | 7 | Current tap position, 0..127 |
| tap_sel | output | 128 | One-hot tap select, bit wiper_pos set |
| store_busy | output | 1 | High while a store into the retained cell is in progress |

## Verification
The assertions check, on every cycle, the properties that concern one cycle at a time:
- the position moves by at most one step outside a recall;
- the position saturates at both ends;
- the position is frozen while the block is deselected, busy or still recalling;
- the retained cell changes only at the end of a store;
- the tap select is one-hot and matches the position.

Some behaviour can only be shown by the bench's scenarios:
- the exact store duration;
- that a deselect with the strobe low stores nothing;
- the restored value after a second reset;
- the rejection of short strobe pulses;
- that a deselect during a store is refused.

The bench combines seeded random strobe, direction, deselect and reset sequences with directed runs to both ends.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Synchronized control pins as seen inside the clock domain.
  typedef struct packed {
    logic sel_n;
    logic inc;
    logic up;
  } ctl_pins_t;

  // Convert a time limit in ns into clock cycles, rounded up, at least one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    if (STAGES > 1) begin : g_deep
      assign chain_d = {chain_q[STAGES-2:0], d[b]};
    end else begin : g_single
      assign chain_d = d[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/wiper_nvcell.sv
module wiper_nvcell #(
  parameter int DW     = 7,
  parameter int WR_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic [DW-1:0] rd_data
);

  localparam int CW = $clog2(WR_CYC + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] snap_q;
  logic [DW-1:0] cell_q;
  logic          accept;
  logic          commit;

  assign accept = wr_req & ~busy_q;
  assign commit = busy_q & (cnt_q == CW'(WR_CYC - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) cnt_d = cnt_q + CW'(1);
    if (commit) busy_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) snap_q <= wr_data;
    end
  end

  // Retained cell: deliberately outside reset so its content survives power-up.
  always_ff @(posedge clk) begin
    if (commit) cell_q <= snap_q;
  end

  assign busy    = busy_q;
  assign rd_data = cell_q;

  // R6: the cell is only written at the end of an active store.
  a_r6_cell_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(cell_q));

  // R10: a request arriving mid-store does not restart the write timer.
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/wiper_ctl.sv
module wiper_ctl #(
  parameter int POS_W   = 7,
  parameter int TAPS    = 128,
  parameter int HI_CYC  = 63,
  parameter int PUD_CYC = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wiper_pkg::ctl_pins_t pins,
  input  logic             nv_busy,
  input  logic [POS_W-1:0] nv_data,
  output logic             store_req,
  output logic [POS_W-1:0] pos
);

  localparam int               HW      = $clog2(HI_CYC + 1);
  localparam int               RW      = $clog2(PUD_CYC + 1);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(TAPS - 1);

  logic             sel_p_q, inc_p_q;
  logic [HW-1:0]    hi_cnt_q, hi_cnt_d;
  logic             rec_q, rec_d;
  logic [RW-1:0]    rec_cnt_q, rec_cnt_d;
  logic [POS_W-1:0] pos_q, pos_d;

  logic fall, desel, hold, wide_hi, step, recall_fire;

  assign fall        = inc_p_q & ~pins.inc;
  assign desel       = ~sel_p_q & pins.sel_n;
  assign hold        = rec_q | nv_busy;
  assign wide_hi     = (hi_cnt_q >= HW'(HI_CYC));
  assign step        = fall & ~pins.sel_n & ~hold & wide_hi;
  assign store_req   = desel & pins.inc & ~hold;
  assign recall_fire = rec_q & (rec_cnt_q == RW'(PUD_CYC - 1));

  always_comb begin
    hi_cnt_d = '0;
    if (pins.inc) hi_cnt_d = wide_hi ? hi_cnt_q : hi_cnt_q + HW'(1);
  end

  always_comb begin
    rec_d     = rec_q;
    rec_cnt_d = rec_cnt_q;
    if (rec_q) rec_cnt_d = rec_cnt_q + RW'(1);
    if (recall_fire) rec_d = 1'b0;
  end

  always_comb begin
    pos_d = pos_q;
    if (recall_fire) begin
      pos_d = nv_data;
    end else if (step) begin
      if (pins.up) begin
        if (pos_q != POS_MAX) pos_d = pos_q + POS_W'(1);
      end else begin
        if (pos_q != '0) pos_d = pos_q - POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_p_q   <= 1'b1;
      inc_p_q   <= 1'b1;
      hi_cnt_q  <= '0;
      rec_q     <= 1'b1;
      rec_cnt_q <= '0;
      pos_q     <= '0;
    end else begin
      sel_p_q   <= pins.sel_n;
      inc_p_q   <= pins.inc;
      hi_cnt_q  <= hi_cnt_d;
      rec_q     <= rec_d;
      rec_cnt_q <= rec_cnt_d;
      pos_q     <= pos_d;
    end
  end

  assign pos = pos_q;

  // R2: outside a recall the position moves by at most one tap per cycle.
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_fire |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + POS_W'(1)
                      || pos_q == $past(pos_q) - POS_W'(1)));

  // R4: saturation at the top end.
  a_r4_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == POS_MAX && pins.up && !recall_fire) |=> pos_q == POS_MAX);

  // R4: saturation at the bottom end.
  a_r4_bot_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0 && !pins.up && !recall_fire) |=> pos_q == '0);

  // R5: deselected means frozen.
  a_r5_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pins.sel_n && !recall_fire) |=> $stable(pos_q));

  // R10: store in progress freezes the position.
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && !recall_fire) |=> $stable(pos_q));

  // R1: recall window keeps position at zero and blocks stores.
  a_r1_recall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q |-> (pos_q == '0 && !store_req));

endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int TAPS  = 128,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  sel
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = (pos == POS_W'(i));
  end

endmodule

// File: rtl/updn_wiper_ctrl.sv
module updn_wiper_ctrl #(
  parameter int CLK_PERIOD_NS  = 4,
  parameter int T_STROBE_HI_NS = 250,
  parameter int T_POWERUP_NS   = 1_000_000,
  parameter int T_STORE_NS     = 15_000_000,
  parameter int TAPS           = 128,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_n,
  input  logic                     inc_strobe,
  input  logic                     dir_up,
  output logic [$clog2(TAPS)-1:0]  wiper_pos,
  output logic [TAPS-1:0]          tap_sel,
  output logic                     store_busy
);

  localparam int POS_W     = $clog2(TAPS);
  localparam int HI_CYC    = wiper_pkg::ns_to_cyc(T_STROBE_HI_NS, CLK_PERIOD_NS);
  localparam int PUD_CYC   = wiper_pkg::ns_to_cyc(T_POWERUP_NS, CLK_PERIOD_NS);
  localparam int STORE_CYC = wiper_pkg::ns_to_cyc(T_STORE_NS, CLK_PERIOD_NS);

  wiper_pkg::ctl_pins_t pins_s;
  logic [2:0]           pins_raw;
  logic [2:0]           pins_sync;
  logic                 store_req;
  logic                 nv_busy;
  logic [POS_W-1:0]     nv_data;
  logic [POS_W-1:0]     pos;

  assign pins_raw = {sel_n, inc_strobe, dir_up};
  assign pins_s   = wiper_pkg::ctl_pins_t'(pins_sync);

  wiper_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_sync)
  );

  wiper_ctl #(.POS_W(POS_W), .TAPS(TAPS), .HI_CYC(HI_CYC), .PUD_CYC(PUD_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (pins_s),
    .nv_busy   (nv_busy),
    .nv_data   (nv_data),
    .store_req (store_req),
    .pos       (pos)
  );

  wiper_nvcell #(.DW(POS_W), .WR_CYC(STORE_CYC)) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (store_req),
    .wr_data (pos),
    .busy    (nv_busy),
    .rd_data (nv_data)
  );

  wiper_decode #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
    .pos (pos),
    .sel (tap_sel)
  );

  assign wiper_pos  = pos;
  assign store_busy = nv_busy;

  // R9: tap select one-hot and aligned with the binary position.
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

endmodule

// File: tb/updn_wiper_ctrl_bench.sv
module updn_wiper_ctrl_bench;

  localparam int CLK_NS    = 4;
  localparam int PUD_CYC   = 100;
  localparam int STORE_CYC = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1;
  logic         inc_strobe = 1'b1;
  logic         dir_up = 1'b0;
  logic [6:0]   wiper_pos;
  logic [127:0] tap_sel;
  logic         store_busy;

  int n_chk = 0;
  int n_fail = 0;
  int busy_cnt = 0;
  int exp_pos = 0;
  int exp_cell = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  updn_wiper_ctrl #(
    .CLK_PERIOD_NS  (CLK_NS),
    .T_STROBE_HI_NS (40),
    .T_POWERUP_NS   (PUD_CYC * CLK_NS),
    .T_STORE_NS     (STORE_CYC * CLK_NS),
    .TAPS           (128),
    .SYNC_STAGES    (2)
  ) u_updn_wiper_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .inc_strobe (inc_strobe),
    .dir_up     (dir_up),
    .wiper_pos  (wiper_pos),
    .tap_sel    (tap_sel),
    .store_busy (store_busy)
  );

  always @(negedge clk) if (rst_n && store_busy) busy_cnt++;

  function automatic int model_step(input int p, input bit up);
    if (up) return (p == 127) ? 127 : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_pos(input string req);
    chk(req, int'(wiper_pos), exp_pos);
    chk("R9", $countones(tap_sel), 1);
    chk("R9", int'(tap_sel[exp_pos[6:0]]), 1);
  endtask

  task automatic pulse(input bit up);
    dir_up = up;
    cyc(2);
    inc_strobe = 1'b0;
    cyc(12);
    inc_strobe = 1'b1;
    cyc(12);
  endtask

  task automatic do_reset();
    sel_n = 1'b1; inc_strobe = 1'b1; dir_up = 1'b0;
    cyc(1);
    rst_n = 1'b0;
    cyc(3);
    chk("R1", int'(wiper_pos), 0);
    chk("R1", int'(store_busy), 0);
    chk("R1", int'(tap_sel[0]), 1);
    rst_n = 1'b1;
  endtask

  // Deselect with the strobe low: the falling strobe itself is a counted step.
  task automatic desel_low();
    int b0;
    b0 = busy_cnt;
    inc_strobe = 1'b0;
    cyc(12);
    exp_pos = model_step(exp_pos, dir_up);
    sel_n = 1'b1;
    cyc(8);
    inc_strobe = 1'b1;
    cyc(12);
    chk("R7", busy_cnt - b0, 0);
  endtask

  task automatic do_store();
    busy_cnt = 0;
    sel_n = 1'b1;
    cyc(STORE_CYC + 20);
    chk("R6", busy_cnt, STORE_CYC);
    exp_cell = exp_pos;
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: first power-up, pins active during the recall window are ignored.
    do_reset();
    cyc(5);
    chk("R1", int'(wiper_pos), 0);
    sel_n = 1'b0;
    cyc(4);
    pulse(1'b1);
    chk("R1", int'(wiper_pos), 0);
    sel_n = 1'b1;
    cyc(PUD_CYC);
    chk("R1", int'(store_busy), 0);
    chk("R1", busy_cnt, 0);
    exp_pos = int'(wiper_pos);
    sel_n = 1'b0;
    cyc(6);

    // R4 bottom, R2 up, R3 direction change, R4 top.
    for (int i = 0; i < 130; i++) begin pulse(1'b0); exp_pos = model_step(exp_pos, 1'b0); end
    chk("R4", int'(wiper_pos), 0);
    pulse(1'b0);
    chk_pos("R4");
    for (int i = 0; i < 3; i++) begin pulse(1'b1); exp_pos = model_step(exp_pos, 1'b1); end
    chk_pos("R2");
    pulse(1'b0); exp_pos = model_step(exp_pos, 1'b0);
    chk_pos("R3");
    for (int i = 0; i < 130; i++) begin pulse(1'b1); exp_pos = model_step(exp_pos, 1'b1); end
    chk("R4", int'(wiper_pos), 127);
    pulse(1'b1);
    chk_pos("R4");
    for (int i = 0; i < 5; i++) begin pulse(1'b0); exp_pos = model_step(exp_pos, 1'b0); end
    chk_pos("R3");

    // R7 deselect with strobe low, then R5 strobes in standby.
    desel_low();
    chk_pos("R7");
    pulse(1'b1);
    pulse(1'b0);
    chk_pos("R5");
    sel_n = 1'b0;
    cyc(6);

    // R11 short high pulse rejected.
    dir_up = 1'b0;
    cyc(2);
    inc_strobe = 1'b0;
    cyc(12);
    exp_pos = model_step(exp_pos, 1'b0);
    inc_strobe = 1'b1;
    cyc(3);
    inc_strobe = 1'b0;
    cyc(12);
    chk_pos("R11");
    inc_strobe = 1'b1;
    cyc(12);

    // R6 store and R10 lockout during store.
    busy_cnt = 0;
    exp_cell = exp_pos;
    sel_n = 1'b1;
    cyc(8);
    chk("R6", int'(store_busy), 1);
    sel_n = 1'b0;
    cyc(6);
    pulse(1'b1);
    chk_pos("R10");
    sel_n = 1'b1;
    cyc(STORE_CYC);
    chk("R10", busy_cnt, STORE_CYC);
    chk("R10", int'(store_busy), 0);
    sel_n = 1'b0;
    cyc(6);
    for (int i = 0; i < 4; i++) begin pulse(1'b1); exp_pos = model_step(exp_pos, 1'b1); end
    chk_pos("R2");

    // R8 recall of the stored value.
    do_reset();
    cyc(PUD_CYC + 10);
    exp_pos = exp_cell;
    chk_pos("R8");
    sel_n = 1'b0;
    cyc(6);

    // Seeded random mix.
    for (int i = 0; i < 250; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 11) begin
        bit up;
        up = 1'($urandom % 2);
        pulse(up);
        exp_pos = model_step(exp_pos, up);
        chk_pos(up ? "R2" : "R3");
      end else if (r < 13) begin
        desel_low();
        chk_pos("R7");
        sel_n = 1'b0;
        cyc(6);
      end else if (r < 14) begin
        do_store();
        chk_pos("R6");
        sel_n = 1'b0;
        cyc(6);
      end else begin
        do_reset();
        cyc(PUD_CYC + 10);
        exp_pos = exp_cell;
        chk_pos("R8");
        sel_n = 1'b0;
        cyc(6);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule